// File: doc/BRIEF.md
# Push-Pull Output Steering Controller

This block is the digital control core of a two-channel gate driver. It takes one single-ended drive pulse stream, given as a non-inverting and an inverting logic input, and turns it into two output commands, `outA` and `outB`. In steering mode a toggle register sends each qualified pulse to the opposite channel, which turns one pulse stream into push-pull drive. In parallel mode both channels follow the drive request together.

Protection is handled in the same path. A stop-comparator trip sets a shutdown latch that is released only after the drive request has stayed off for a minimum number of clock cycles, so the shutdown acts pulse by pulse. A thermal fault or a missing supply-good flag forces both outputs low. Each channel also has an inhibit input that holds it off while the opposite switch still conducts, which gives dead time. The same minimum off-time gates the steering toggle, so a pulse that follows a short gap is not steered as a new alternation. All eight control inputs are asynchronous and pass through synchronizer flops. The outputs are registered.

Top module: `pp_steer_ctrl`

## Requirements
- R1: The drive request is on only when `nonInvIn` is 1 and `invIn` is 0. The other three combinations mean off. An input change reaches the outputs `SYNC_STAGES`+1 clock edges later (3 by default).
- R2: While `supplyOkIn` is 0, both outputs are 0.
- R3: With `steerEnIn` at 0 (parallel mode), `outA` and `outB` both equal the drive request.
- R4: With `steerEnIn` at 1, `outA` and `outB` are never both 1. Successive qualified pulses go alternately to A and B.
- R5: The toggle register flips only when the synchronized drive request has been off for at least `MIN_OFF_CYC` consecutive cycles after a pulse. A pulse that follows a shorter gap goes to the same channel as the pulse before it.
- R6: A stop trip forces both outputs to 0 and sets a latch. The latch keeps both outputs at 0 until the drive request has been off for at least `MIN_OFF_CYC` consecutive cycles.
- R7: While `thermFaultIn` is 1, both outputs are 0 whatever the other inputs are.
- R8: While `inhibitAIn` is 1, `outA` is 0. While `inhibitBIn` is 1, `outB` is 0.
- R9: If a stop trip and the latch-clear condition occur in the same cycle, the latch is set.
- R10: After reset both outputs are 0, the stop latch is clear, and the first pulse goes to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nonInvIn | input | 1 | Non-inverting drive input |
| invIn | input | 1 | Inverting drive input |
| steerEnIn | input | 1 | 1 = alternate channels, 0 = parallel |
| stopTripIn | input | 1 | Stop comparator trip flag |
| thermFaultIn | input | 1 | Over-temperature flag |
| supplyOkIn | input | 1 | Supply-good enable |
| inhibitAIn | input | 1 | Holds channel A off |
| inhibitBIn | input | 1 | Holds channel B off |
| outA | output | 1 | Channel A drive command |
| outB | output | 1 | Channel B drive command |

## Verification
Every input passes through two synchronizer flops and then one output register, so an input change driven between edges appears on `outA`/`outB` after the third rising edge. The bench drives on falling edges, waits three of them and samples there. A gap of N low cycles at the input is N low cycles at the counter, so the bench predicts a toggle or a latch release exactly when N reaches `MIN_OFF_CYC`. It sweeps gaps across that limit and places the stop release in the same cycle as the drive rise to test R9.

// File: rtl/pp_steer_pkg.sv
package pp_steer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic toggleSel;  // flip channel selection
    logic clearStop;  // off-time met, may release shutdown latch
    logic setStop;    // stop trip seen
  } steer_stb_t;

  // Synchronized input bundle
  typedef struct packed {
    logic nonInv;
    logic inv;
    logic steerEn;
    logic stopTrip;
    logic thermFault;
    logic supplyOk;
    logic inhA;
    logic inhB;
  } steer_in_t;

  localparam int unsigned STEER_IN_W = $bits(steer_in_t);

endpackage

// File: rtl/pp_steer_sync.sv
module pp_steer_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= dIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dOut = stg[STAGES-1];

endmodule

// File: rtl/pp_steer_ctl.sv
module pp_steer_ctl
  import pp_steer_pkg::*;
#(
  parameter int unsigned MIN_OFF_CYC = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nonInvS,
  input  logic       invS,
  input  logic       stopS,
  output logic       driveOn,
  output steer_stb_t stb
);

  localparam int unsigned CNT_W = $clog2(MIN_OFF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_OFF_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_OFF_CYC - 1);

  logic [CNT_W-1:0] offCnt;
  logic             armed;   // a pulse occurred since the last toggle
  logic             offMet;

  assign driveOn = nonInvS & ~invS;
  assign offMet  = ~driveOn & (offCnt >= CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (driveOn) begin
      offCnt <= '0;
    end else if (offCnt != CNT_MAX) begin
      offCnt <= offCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armed <= 1'b0;
    else if (driveOn)        armed <= 1'b1;
    else if (stb.toggleSel)  armed <= 1'b0;
  end

  always_comb begin
    stb.toggleSel = armed & ~driveOn & (offCnt == CNT_LAST);
    stb.clearStop = offMet;
    stb.setStop   = stopS;
  end

  // R5: off-time counter never passes its limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    offCnt <= CNT_MAX);
  // R5: an active request restarts the off-time count
  a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rstN)
    driveOn |=> (offCnt == '0));

endmodule

// File: rtl/pp_steer_dp.sv
module pp_steer_dp
  import pp_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       driveOn,
  input  logic       steerS,
  input  logic       stopS,
  input  logic       thermS,
  input  logic       supplyS,
  input  logic       inhAS,
  input  logic       inhBS,
  input  steer_stb_t stb,
  output logic       outA,
  output logic       outB
);

  logic selB;       // 0: next pulse to A, 1: to B
  logic stopLatch;
  logic goOn;
  logic nextA;
  logic nextB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              selB <= 1'b0;
    else if (stb.toggleSel) selB <= ~selB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stopLatch <= 1'b0;
    else if (stb.setStop)   stopLatch <= 1'b1;
    else if (stb.clearStop) stopLatch <= 1'b0;
  end

  always_comb begin
    goOn  = driveOn & supplyS & ~thermS & ~stopLatch & ~stopS;
    nextA = goOn & ~inhAS & (~steerS | ~selB);
    nextB = goOn & ~inhBS & (~steerS |  selB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= 1'b0;
      outB <= 1'b0;
    end else begin
      outA <= nextA;
      outB <= nextB;
    end
  end

  a_r2_supply_low: assert property (@(posedge clk) disable iff (!rstN)
    !supplyS |=> (!outA && !outB));
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rstN)
    steerS |=> !(outA && outB));
  a_r6_latch_blocks: assert property (@(posedge clk) disable iff (!rstN)
    stopLatch |=> (!outA && !outB));
  a_r7_thermal: assert property (@(posedge clk) disable iff (!rstN)
    thermS |=> (!outA && !outB));
  a_r8_inhibit_a: assert property (@(posedge clk) disable iff (!rstN)
    inhAS |=> !outA);
  a_r8_inhibit_b: assert property (@(posedge clk) disable iff (!rstN)
    inhBS |=> !outB);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    stopS |=> stopLatch);

endmodule

// File: rtl/pp_steer_ctrl.sv
module pp_steer_ctrl
  import pp_steer_pkg::*;
#(
  parameter int unsigned MIN_OFF_CYC = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic nonInvIn,
  input  logic invIn,
  input  logic steerEnIn,
  input  logic stopTripIn,
  input  logic thermFaultIn,
  input  logic supplyOkIn,
  input  logic inhibitAIn,
  input  logic inhibitBIn,
  output logic outA,
  output logic outB
);

  steer_in_t  rawIn;
  steer_in_t  syncIn;
  steer_stb_t stb;
  logic       driveOn;

  assign rawIn = '{nonInv: nonInvIn, inv: invIn, steerEn: steerEnIn,
                   stopTrip: stopTripIn, thermFault: thermFaultIn,
                   supplyOk: supplyOkIn, inhA: inhibitAIn, inhB: inhibitBIn};

  pp_steer_sync #(.WIDTH(STEER_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .dOut (syncIn)
  );

  pp_steer_ctl #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .nonInvS (syncIn.nonInv),
    .invS    (syncIn.inv),
    .stopS   (syncIn.stopTrip),
    .driveOn (driveOn),
    .stb     (stb)
  );

  pp_steer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .driveOn (driveOn),
    .steerS  (syncIn.steerEn),
    .stopS   (syncIn.stopTrip),
    .thermS  (syncIn.thermFault),
    .supplyS (syncIn.supplyOk),
    .inhAS   (syncIn.inhA),
    .inhBS   (syncIn.inhB),
    .stb     (stb),
    .outA    (outA),
    .outB    (outB)
  );

endmodule

// File: tb/pp_steer_ctrl_tb.sv
module pp_steer_ctrl_tb;

  localparam int unsigned MIN_OFF = 4;
  localparam int unsigned LAT     = 3;

  logic clk = 1'b0;
  logic rstN;
  logic niIn, invIn, steerIn, stopIn, thermIn, supplyIn, inhAIn, inhBIn;
  logic outA, outB;
  int   nTests = 0;
  int   nFail  = 0;
  bit   done   = 0;

  always #5 clk = ~clk;

  pp_steer_ctrl #(.MIN_OFF_CYC(MIN_OFF), .SYNC_STAGES(2)) u_dut (
    .clk (clk), .rstN (rstN),
    .nonInvIn (niIn), .invIn (invIn), .steerEnIn (steerIn),
    .stopTripIn (stopIn), .thermFaultIn (thermIn), .supplyOkIn (supplyIn),
    .inhibitAIn (inhAIn), .inhibitBIn (inhBIn),
    .outA (outA), .outB (outB)
  );

  task automatic check(input string tag, input logic eA, input logic eB);
    nTests++;
    if (outA !== eA || outB !== eB) begin
      nFail++;
      $display("FAIL %s: outA=%0b outB=%0b expected outA=%0b outB=%0b",
               tag, outA, outB, eA, eB);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    niIn = 0; invIn = 0; steerIn = 0; stopIn = 0; thermIn = 0;
    supplyIn = 1; inhAIn = 0; inhBIn = 0;
    waitN(3);
    check("R10 outputs low in reset", 1'b0, 1'b0);
    rstN = 1'b1;
    waitN(MIN_OFF + 4);
    check("R10 outputs low after reset", 1'b0, 1'b0);
  endtask

  // low gap of 'gap' cycles, then a 5-cycle pulse, sampled LAT cycles in
  task automatic pulse(input int gap, input logic eA, input logic eB, input string tag);
    niIn = 1'b0;
    waitN(gap);
    niIn = 1'b1;
    waitN(LAT);
    check(tag, eA, eB);
    waitN(2);
    niIn = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R1/R2/R3/R7: exhaustive over ni, inv, supply, thermal in parallel mode
    for (int v = 0; v < 16; v++) begin
      logic e;
      string tag;
      niIn = v[0]; invIn = v[1]; supplyIn = v[2]; thermIn = v[3];
      waitN(LAT);
      e = v[0] & ~v[1] & v[2] & ~v[3];
      if (!v[2])      tag = "R2 supply low";
      else if (v[3])  tag = "R7 thermal fault";
      else            tag = "R1/R3 request decode, parallel";
      check(tag, e, e);
    end
    niIn = 0; invIn = 0; supplyIn = 1; thermIn = 0;
    waitN(MIN_OFF + 2);

    // R8: inhibit sweep with drive on, parallel mode
    niIn = 1;
    for (int v = 0; v < 4; v++) begin
      inhAIn = v[0]; inhBIn = v[1];
      waitN(LAT);
      check("R8 inhibit", ~v[0], ~v[1]);
    end
    niIn = 0; inhAIn = 0; inhBIn = 0;

    // R10/R4/R5: steering after a fresh reset
    doReset();
    steerIn = 1'b1;
    waitN(LAT);
    begin
      logic selB = 1'b0;
      pulse(MIN_OFF + 4, 1'b1, 1'b0, "R10 first pulse to A");
      for (int g = 1; g <= int'(MIN_OFF) + 2; g++) begin
        if (g >= int'(MIN_OFF)) selB = ~selB;
        pulse(g, ~selB, selB, (g >= int'(MIN_OFF)) ? "R4 alternation" : "R5 short gap suppressed");
      end
      for (int k = 0; k < 4; k++) begin
        selB = ~selB;
        pulse(MIN_OFF, ~selB, selB, "R4/R5 gap equal to limit");
      end
      // R8 in steering: inhibit the channel that is due next
      selB = ~selB;
      if (selB) inhBIn = 1'b1; else inhAIn = 1'b1;
      pulse(MIN_OFF + 1, 1'b0, 1'b0, "R8 inhibit in steering");
      inhAIn = 0; inhBIn = 0;
    end

    // R6: stop latch, parallel mode
    doReset();
    niIn = 1'b1;
    waitN(LAT);
    check("R3 pulse before stop", 1'b1, 1'b1);
    stopIn = 1'b1;
    waitN(LAT);
    check("R6 stop forces low", 1'b0, 1'b0);
    stopIn = 1'b0;
    waitN(5);
    check("R6 latch holds within pulse", 1'b0, 1'b0);
    pulse(MIN_OFF - 2, 1'b0, 1'b0, "R6 short gap keeps latch");
    pulse(MIN_OFF, 1'b1, 1'b1, "R6 latch released after off-time");

    // R9: trip held through a qualified gap, released as drive rises
    niIn = 1'b0;
    stopIn = 1'b1;
    waitN(MIN_OFF + 4);
    stopIn = 1'b0;
    niIn = 1'b1;
    waitN(LAT);
    check("R9 set wins over clear", 1'b0, 1'b0);
    waitN(2);
    pulse(MIN_OFF + 1, 1'b1, 1'b1, "R9 release after next off-time");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule